// File: doc/BRIEF.md
# On-chip XRAM access steering controller

This block sits between a CPU's external-data-space access port and two possible targets. One target is a small RAM on the die that occupies the top of the 16-bit external data address space. The other is the multiplexed external bus: port 0 carries the low address byte and then the data, and port 2 carries the high address byte. For every accepted access the block decides which target serves it. It drives the internal RAM's enable, write strobe and address, or the external address latch strobe, the active-low read/write strobes and the two port drive enables.

A one-byte system control register at special-function address B1h holds two control bits. Bit 0 disables the on-chip RAM and resets to 1. It is protected: it changes only when a separate protected-write strobe accompanies the register write. Bit 1 selects visible mode. In this mode an access to the on-chip RAM is mirrored onto the ports and strobes so that it can be observed from outside.

An access takes two cycles. In the address cycle the request is presented and the target is chosen. The data cycle follows. Read data comes back to the CPU two cycles after the request on both paths, so the CPU cannot tell the paths apart by timing.

Top module: `xram_steer`

## Requirements
- R1: After reset the register reads A1h: the RAM is disabled and visible mode is off. Also, ram_en is low, bus_rd_n and bus_wr_n are high, and acc_busy and acc_rvalid are low.
- R2: Reading address B1h returns {1010, 00, visible, disable} from bit 7 down to bit 0. Bits 3 and 2 ignore writes. Any other sfr_addr reads 00h, and writes to any other address change nothing.
- R3: An ordinary write (sfr_we=1, sfr_prot_we=0) at B1h updates bit 1 but leaves bit 0 unchanged. Bit 0 takes sfr_wdata[0] only when sfr_prot_we=1 accompanies the write. A register write takes effect on the next cycle.
- R4: While bit 0 is 1, every accepted access runs as an external bus cycle, and ram_en stays low.
- R5: While bit 0 is 0, an accepted access with acc_addr at or above XRAM_BASE (default F800h) is internal. For such an access, in the address cycle, ram_en=1, ram_we=acc_we, ram_addr carries the low address bits and ram_wdata carries acc_wdata. Addresses below the base go to the external bus.
- R6: An external bus cycle behaves as follows. In the address cycle bus_ale=1, p0_oe=1 and p2_oe=1, with p0_out equal to the low address byte and p2_out equal to the high address byte. In the following data cycle, p2 keeps driving the high byte, and either bus_rd_n (read) or bus_wr_n (write) is 0. On a write, p0 drives the write data; on a read, p0 is released.
- R7: An internal access with bit 1 at 0 leaves bus_ale low, both strobes high and both ports undriven.
- R8: An internal access with bit 1 at 1 also runs the R6 bus sequence. On a read, p0 drives the RAM read data in the data cycle.
- R9: Bit 1 has no effect on accesses below the base or while bit 0 is 1. These accesses run as plain R6 external cycles.
- R10: For a read accepted in cycle N, acc_rvalid=1 in cycle N+2. In that cycle acc_rdata carries ram_rdata (internal) or the p0_in value sampled in the data cycle (external).
- R11: During the data cycle acc_busy=1. A request presented in that cycle is ignored: no RAM strobe, no bus cycle and no read data result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Register write strobe |
| sfr_prot_we | input | 1 | Protected-write qualifier for bit 0 |
| sfr_rdata | output | 8 | Register read data (combinational) |
| acc_valid | input | 1 | External-data access request |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Access write data |
| acc_busy | output | 1 | Data cycle in progress; requests ignored |
| acc_rvalid | output | 1 | Read data valid |
| acc_rdata | output | 8 | Read data to the CPU |
| ram_en | output | 1 | Internal RAM enable |
| ram_we | output | 1 | Internal RAM write strobe |
| ram_addr | output | 11 | Internal RAM address |
| ram_wdata | output | 8 | Internal RAM write data |
| ram_rdata | input | 8 | Internal RAM read data (one cycle after enable) |
| bus_ale | output | 1 | External address latch strobe |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_wr_n | output | 1 | External write strobe, active low |
| p0_oe | output | 1 | Port 0 drive enable |
| p0_out | output | 8 | Port 0 drive value (low address, then data) |
| p0_in | input | 8 | Port 0 input data |
| p2_oe | output | 1 | Port 2 drive enable |
| p2_out | output | 8 | Port 2 drive value (high address) |

## Verification
The RAM enable, the address-latch strobe and the cycle-0 port values depend combinationally on the request. They are due in the same cycle the request is presented. The read/write strobes, the data-cycle port values and acc_busy are due one cycle later, and acc_rvalid with its data two cycles later. A register write shows in the readback on the next cycle. The bench drives inputs shortly after each rising edge. A behavioural model, updated at the same edges the design registers on, predicts every output, and the outputs are compared at the falling edge, so each value is checked in exactly the cycle it is due.

// File: rtl/xram_steer_pkg.sv
package xram_steer_pkg;

  // Control bits held by the system control register.
  typedef struct packed {
    logic vis;  // mirror on-chip RAM accesses onto the external bus
    logic dis;  // on-chip RAM disabled (protected)
  } xctrl_t;

  localparam logic [3:0] XCTRL_ID_NIBBLE = 4'b1010;

  localparam xctrl_t XCTRL_RESET = '{vis: 1'b0, dis: 1'b1};

endpackage

// File: rtl/xram_sysctl.sv
module xram_sysctl
  import xram_steer_pkg::*;
#(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [SFR_AW-1:0] REG_ADDR = 8'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [1:0]        sfr_wbits,
  input  logic              sfr_we,
  input  logic              sfr_prot_we,
  output xctrl_t            ctrl,
  output logic [DATA_W-1:0] sfr_rdata
);

  logic   reg_sel;
  logic   reg_wr;
  xctrl_t ctrl_q;
  xctrl_t ctrl_d;

  assign reg_sel = (sfr_addr == REG_ADDR);
  assign reg_wr  = reg_sel & sfr_we;

  // Next state: bit 1 follows any write, bit 0 only a protected one.
  always_comb begin
    ctrl_d     = ctrl_q;
    ctrl_d.vis = sfr_wbits[1];
    if (sfr_prot_we) begin
      ctrl_d.dis = sfr_wbits[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= XCTRL_RESET;
    end else if (reg_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Readback: fixed identification nibble on top, reserved bits zero.
  always_comb begin
    sfr_rdata = '0;
    if (reg_sel) begin
      sfr_rdata[DATA_W-1 -: 4] = XCTRL_ID_NIBBLE;
      sfr_rdata[1]             = ctrl_q.vis;
      sfr_rdata[0]             = ctrl_q.dis;
    end
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/xram_decode.sv
module xram_decode
  import xram_steer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned XRAM_BASE = 'hF800
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy,
  input  xctrl_t            ctrl,
  output logic              accept,
  output logic              int_hit,
  output logic              bus_cycle
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(XRAM_BASE);

  logic in_range;

  assign in_range = (acc_addr >= BASE_V);

  always_comb begin
    accept    = acc_valid & ~busy;
    int_hit   = accept & in_range & ~ctrl.dis;
    // External target, or internal target mirrored in visible mode.
    bus_cycle = accept & (~int_hit | ctrl.vis);
  end

endmodule

// File: rtl/xram_bus.sv
module xram_bus #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              int_hit,
  input  logic              bus_cycle,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] p0_in,
  output logic              busy,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p0_out,
  output logic              p2_oe,
  output logic [ADDR_W-DATA_W-1:0] p2_out,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned HI_W = ADDR_W - DATA_W;

  // Data-cycle state
  logic              dp_valid_q, dp_valid_d;
  logic              dp_we_q,    dp_we_d;
  logic              dp_int_q,   dp_int_d;
  logic              dp_bus_q,   dp_bus_d;
  logic [HI_W-1:0]   dp_hi_q,    dp_hi_d;
  logic [DATA_W-1:0] dp_wd_q,    dp_wd_d;
  logic              dp_load;

  // Read return state
  logic              rv_q,  rv_d;
  logic [DATA_W-1:0] rd_q,  rd_d;
  logic              rd_load;

  // Next state for the data cycle.
  always_comb begin
    dp_valid_d = accept;
    dp_we_d    = acc_we;
    dp_int_d   = int_hit;
    dp_bus_d   = bus_cycle;
    dp_hi_d    = acc_addr[ADDR_W-1:DATA_W];
    dp_wd_d    = acc_wdata;
    dp_load    = accept;
  end

  // Next state for read return: sampled at the end of the data cycle.
  always_comb begin
    rv_d    = dp_valid_q & ~dp_we_q;
    rd_d    = dp_int_q ? ram_rdata : p0_in;
    rd_load = rv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid_q <= 1'b0;
      dp_we_q    <= 1'b0;
      dp_int_q   <= 1'b0;
      dp_bus_q   <= 1'b0;
    end else begin
      dp_valid_q <= dp_valid_d;
      dp_we_q    <= dp_we_d;
      dp_int_q   <= dp_int_d;
      dp_bus_q   <= dp_bus_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_hi_q <= '0;
      dp_wd_q <= '0;
    end else if (dp_load) begin
      dp_hi_q <= dp_hi_d;
      dp_wd_q <= dp_wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_load) begin
      rd_q <= rd_d;
    end
  end

  // Pin drive: address cycle from the live request, data cycle from state.
  // The two never overlap because a request is refused while busy.
  always_comb begin
    bus_ale  = bus_cycle;
    bus_rd_n = ~(dp_bus_q & ~dp_we_q);
    bus_wr_n = ~(dp_bus_q &  dp_we_q);
    p2_oe    = bus_cycle | dp_bus_q;
    p2_out   = bus_cycle ? acc_addr[ADDR_W-1:DATA_W] : dp_hi_q;
    p0_oe    = bus_cycle | (dp_bus_q & (dp_we_q | dp_int_q));
    if (bus_cycle) begin
      p0_out = acc_addr[DATA_W-1:0];
    end else if (dp_we_q) begin
      p0_out = dp_wd_q;
    end else begin
      p0_out = ram_rdata;
    end
  end

  assign busy   = dp_valid_q;
  assign rvalid = rv_q;
  assign rdata  = rd_q;

endmodule

// File: rtl/xram_steer.sv
module xram_steer
  import xram_steer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SFR_AW    = 8,
  parameter logic [SFR_AW-1:0] SYSCTL_ADDR = 8'hB1,
  parameter int unsigned XRAM_BASE = 'hF800,
  parameter int unsigned RAM_AW    = $clog2((2**ADDR_W) - XRAM_BASE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SFR_AW-1:0]        sfr_addr,
  input  logic [DATA_W-1:0]        sfr_wdata,
  input  logic                     sfr_we,
  input  logic                     sfr_prot_we,
  output logic [DATA_W-1:0]        sfr_rdata,
  input  logic                     acc_valid,
  input  logic                     acc_we,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [DATA_W-1:0]        acc_wdata,
  output logic                     acc_busy,
  output logic                     acc_rvalid,
  output logic [DATA_W-1:0]        acc_rdata,
  output logic                     ram_en,
  output logic                     ram_we,
  output logic [RAM_AW-1:0]        ram_addr,
  output logic [DATA_W-1:0]        ram_wdata,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic                     p0_oe,
  output logic [DATA_W-1:0]        p0_out,
  input  logic [DATA_W-1:0]        p0_in,
  output logic                     p2_oe,
  output logic [ADDR_W-DATA_W-1:0] p2_out
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q;
  logic srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  xctrl_t ctrl;
  logic   accept;
  logic   int_hit;
  logic   bus_cycle;
  logic   unused_wbits;

  assign unused_wbits = ^sfr_wdata[DATA_W-1:2];

  xram_sysctl #(
    .SFR_AW   (SFR_AW),
    .DATA_W   (DATA_W),
    .REG_ADDR (SYSCTL_ADDR)
  ) u_sysctl (
    .clk         (clk),
    .rst_n       (srst_n),
    .sfr_addr    (sfr_addr),
    .sfr_wbits   (sfr_wdata[1:0]),
    .sfr_we      (sfr_we),
    .sfr_prot_we (sfr_prot_we),
    .ctrl        (ctrl),
    .sfr_rdata   (sfr_rdata)
  );

  xram_decode #(
    .ADDR_W    (ADDR_W),
    .XRAM_BASE (XRAM_BASE)
  ) u_decode (
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .busy      (acc_busy),
    .ctrl      (ctrl),
    .accept    (accept),
    .int_hit   (int_hit),
    .bus_cycle (bus_cycle)
  );

  xram_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_bus (
    .clk       (clk),
    .rst_n     (srst_n),
    .accept    (accept),
    .int_hit   (int_hit),
    .bus_cycle (bus_cycle),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .ram_rdata (ram_rdata),
    .p0_in     (p0_in),
    .busy      (acc_busy),
    .bus_ale   (bus_ale),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .p0_oe     (p0_oe),
    .p0_out    (p0_out),
    .p2_oe     (p2_oe),
    .p2_out    (p2_out),
    .rvalid    (acc_rvalid),
    .rdata     (acc_rdata)
  );

  // RAM strobes are taken straight from the address cycle decode.
  assign ram_en    = int_hit;
  assign ram_we    = int_hit & acc_we;
  assign ram_addr  = acc_addr[RAM_AW-1:0];
  assign ram_wdata = acc_wdata;

endmodule

// File: rtl/xram_steer_chk.sv
module xram_steer_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SFR_AW    = 8,
  parameter logic [SFR_AW-1:0] SYSCTL_ADDR = 8'hB1,
  parameter int unsigned XRAM_BASE = 'hF800
) (
  input logic              clk,
  input logic              srst_n,
  input logic [SFR_AW-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic              sfr_we,
  input logic              sfr_prot_we,
  input logic              ctrl_dis,
  input logic              ctrl_vis,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_busy,
  input logic              acc_rvalid,
  input logic              ram_en,
  input logic              bus_ale,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              p0_oe,
  input logic              p2_oe
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(XRAM_BASE);

  // R2
  sysctl_readback_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sfr_addr == SYSCTL_ADDR) |-> (sfr_rdata[DATA_W-1:2] == 6'b101000));

  // R3
  dis_protected_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sfr_we && !sfr_prot_we) |=> $stable(ctrl_dis));

  // R4
  dis_blocks_ram_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl_dis |-> !ram_en);

  // R5
  ram_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ram_en |-> (acc_addr >= BASE_V));

  // R6
  ale_drives_ports_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bus_ale |-> (p0_oe && p2_oe));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R7
  hidden_ram_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ram_en && !ctrl_vis) |-> !bus_ale);

  // R10
  read_return_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_valid && !acc_busy && !acc_we) |=> ##1 acc_rvalid);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!srst_n)
    acc_busy |-> (!ram_en && !bus_ale));

endmodule

bind xram_steer xram_steer_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .SFR_AW      (SFR_AW),
  .SYSCTL_ADDR (SYSCTL_ADDR),
  .XRAM_BASE   (XRAM_BASE)
) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .sfr_addr    (sfr_addr),
  .sfr_rdata   (sfr_rdata),
  .sfr_we      (sfr_we),
  .sfr_prot_we (sfr_prot_we),
  .ctrl_dis    (ctrl.dis),
  .ctrl_vis    (ctrl.vis),
  .acc_valid   (acc_valid),
  .acc_we      (acc_we),
  .acc_addr    (acc_addr),
  .acc_busy    (acc_busy),
  .acc_rvalid  (acc_rvalid),
  .ram_en      (ram_en),
  .bus_ale     (bus_ale),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .p0_oe       (p0_oe),
  .p2_oe       (p2_oe)
);

// File: tb/tb_xram_steer.sv
`timescale 1ns/1ps
module tb_xram_steer;

  localparam int BASE = 'hF800;

  logic        clk;
  logic        rst_n;
  logic [7:0]  sfr_addr;
  logic [7:0]  sfr_wdata;
  logic        sfr_we;
  logic        sfr_prot_we;
  logic [7:0]  sfr_rdata;
  logic        acc_valid;
  logic        acc_we;
  logic [15:0] acc_addr;
  logic [7:0]  acc_wdata;
  logic        acc_busy;
  logic        acc_rvalid;
  logic [7:0]  acc_rdata;
  logic        ram_en;
  logic        ram_we;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        bus_ale;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic        p0_oe;
  logic [7:0]  p0_out;
  logic [7:0]  p0_in;
  logic        p2_oe;
  logic [7:0]  p2_out;

  xram_steer dut (
    .clk(clk), .rst_n(rst_n),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .sfr_prot_we(sfr_prot_we), .sfr_rdata(sfr_rdata),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_busy(acc_busy), .acc_rvalid(acc_rvalid),
    .acc_rdata(acc_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .p0_oe(p0_oe), .p0_out(p0_out), .p0_in(p0_in),
    .p2_oe(p2_oe), .p2_out(p2_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Environment RAM answering the design's RAM port.
  logic [7:0] env_mem [0:2047];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) env_mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= env_mem[ram_addr];
    end
  end

  // Behavioural reference model.
  logic [7:0] m_mem [0:2047];
  logic [7:0] m_ramq;
  bit m_dis, m_vis, m_dpv, m_dpwe, m_dpint, m_dpbus, m_rv;
  logic [7:0] m_hi, m_wd, m_rd;

  always @(posedge clk) begin
    bit ok, ih, bs, n_rv;
    logic [7:0] n_rd;
    if (!rst_n) begin
      m_dis = 1; m_vis = 0; m_dpv = 0; m_dpwe = 0; m_dpint = 0; m_dpbus = 0;
      m_rv = 0; m_hi = 0; m_wd = 0; m_rd = 0;
    end else begin
      ok = acc_valid && !m_dpv;
      ih = ok && !m_dis && (int'(acc_addr) >= BASE);
      bs = ok && (!ih || m_vis);
      n_rv = m_dpv && !m_dpwe;
      n_rd = m_dpint ? m_ramq : p0_in;
      if (ih) begin
        if (acc_we) m_mem[acc_addr[10:0]] = acc_wdata;
        else        m_ramq = m_mem[acc_addr[10:0]];
      end
      if (n_rv) m_rd = n_rd;
      m_rv = n_rv;
      m_dpv = ok; m_dpwe = acc_we; m_dpint = ih; m_dpbus = bs;
      if (ok) begin m_hi = acc_addr[15:8]; m_wd = acc_wdata; end
      if (sfr_we && sfr_addr == 8'hB1) begin
        m_vis = sfr_wdata[1];
        if (sfr_prot_we) m_dis = sfr_wdata[0];
      end
    end
  end

  // Compare every output at the falling edge.
  always @(negedge clk) begin
    bit ok, ih, bs, e_p0oe, e_p2oe;
    logic [7:0] e_p0, e_p2, e_sfr;
    if (cmp_on) begin
      ok = acc_valid && !m_dpv;
      ih = ok && !m_dis && (int'(acc_addr) >= BASE);
      bs = ok && (!ih || m_vis);
      e_sfr  = (sfr_addr == 8'hB1) ? {4'b1010, 2'b00, m_vis, m_dis} : 8'h00;
      e_p2oe = bs || m_dpbus;
      e_p2   = bs ? acc_addr[15:8] : m_hi;
      e_p0oe = bs || (m_dpbus && (m_dpwe || m_dpint));
      e_p0   = bs ? acc_addr[7:0] : (m_dpwe ? m_wd : m_ramq);
      chk("R2 sfr_rdata", 32'(sfr_rdata), 32'(e_sfr));
      chk("R5 ram_en", 32'(ram_en), 32'(ih));
      chk("R5 ram_we", 32'(ram_we), 32'(ih && acc_we));
      if (ih) begin
        chk("R5 ram_addr", 32'(ram_addr), 32'(acc_addr[10:0]));
        chk("R5 ram_wdata", 32'(ram_wdata), 32'(acc_wdata));
      end
      chk("R6 bus_ale", 32'(bus_ale), 32'(bs));
      chk("R6 bus_rd_n", 32'(bus_rd_n), 32'(!(m_dpbus && !m_dpwe)));
      chk("R6 bus_wr_n", 32'(bus_wr_n), 32'(!(m_dpbus && m_dpwe)));
      chk("R6 p2_oe", 32'(p2_oe), 32'(e_p2oe));
      if (e_p2oe) chk("R6 p2_out", 32'(p2_out), 32'(e_p2));
      chk("R8 p0_oe", 32'(p0_oe), 32'(e_p0oe));
      if (e_p0oe) chk("R8 p0_out", 32'(p0_out), 32'(e_p0));
      chk("R11 acc_busy", 32'(acc_busy), 32'(m_dpv));
      chk("R10 acc_rvalid", 32'(acc_rvalid), 32'(m_rv));
      if (m_rv) chk("R10 acc_rdata", 32'(acc_rdata), 32'(m_rd));
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d, input bit prot);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1; sfr_prot_we = prot;
    tick();
    sfr_we = 0; sfr_prot_we = 0; sfr_addr = 8'hB1;
  endtask

  task automatic acc(input bit we, input logic [15:0] a, input logic [7:0] wd,
                     input logic [7:0] ext, input bit exp_int, input bit exp_bus,
                     input string tag);
    acc_valid = 1; acc_we = we; acc_addr = a; acc_wdata = wd; p0_in = ext;
    @(negedge clk);
    chk({tag, " ram_en in address cycle"}, 32'(ram_en), 32'(exp_int));
    chk({tag, " bus_ale in address cycle"}, 32'(bus_ale), 32'(exp_bus));
    tick();
    acc_valid = 0;
    @(negedge clk);
    chk({tag, " strobe in data cycle"}, 32'(!bus_rd_n || !bus_wr_n), 32'(exp_bus));
    tick();
    tick();
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      env_mem[i] = 8'((i * 7 + 3) & 255);
      m_mem[i]   = 8'((i * 7 + 3) & 255);
    end
    ram_rdata = 8'h00; m_ramq = 8'h00;
    rst_n = 0; sfr_addr = 8'hB1; sfr_wdata = 0; sfr_we = 0; sfr_prot_we = 0;
    acc_valid = 0; acc_we = 0; acc_addr = 0; acc_wdata = 0; p0_in = 0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) tick();
    cmp_on = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 sysctl reset value", 32'(sfr_rdata), 32'h0000_00A1);
    chk("R1 ram_en idle", 32'(ram_en), 32'd0);
    chk("R1 strobes idle", 32'({bus_rd_n, bus_wr_n}), 32'd3);
    chk("R1 rvalid idle", 32'({acc_busy, acc_rvalid}), 32'd0);
    tick();

    // R4 RAM disabled: everything external
    acc(0, 16'hF900, 8'h00, 8'h3C, 0, 1, "R4 disabled read");
    acc(1, 16'hFFF0, 8'h5A, 8'h00, 0, 1, "R4 disabled write");
    acc(1, 16'h0100, 8'hA5, 8'h00, 0, 1, "R6 low write");
    acc(0, 16'h2345, 8'h00, 8'hC3, 0, 1, "R6 low read");

    // R3 ordinary write cannot clear bit 0
    sfr_wr(8'hB1, 8'h00, 0);
    @(negedge clk); chk("R3 bit0 kept on plain write", 32'(sfr_rdata), 32'h0000_00A1);
    tick();
    // R2 reserved bits ignore writes
    sfr_wr(8'hB1, 8'h0C, 0);
    @(negedge clk); chk("R2 reserved bits read zero", 32'(sfr_rdata), 32'h0000_00A1);
    tick();
    // R2 other address: no effect, reads zero
    sfr_wr(8'hB2, 8'hFF, 1);
    @(negedge clk); chk("R2 other address write ignored", 32'(sfr_rdata), 32'h0000_00A1);
    sfr_addr = 8'hB2;
    @(negedge clk); chk("R2 other address reads zero", 32'(sfr_rdata), 32'h0);
    sfr_addr = 8'hB1;
    tick();
    // R3 protected write enables RAM
    sfr_wr(8'hB1, 8'h00, 1);
    @(negedge clk); chk("R3 bit0 cleared by protected write", 32'(sfr_rdata), 32'h0000_00A0);
    tick();

    // R7 hidden internal accesses; R5 boundary
    acc(1, 16'hFFFF, 8'h55, 8'h00, 1, 0, "R7 internal write");
    acc(0, 16'hFFFF, 8'h00, 8'hEE, 1, 0, "R7 internal read");
    acc(1, 16'hF800, 8'h11, 8'h00, 1, 0, "R5 base write");
    acc(0, 16'hF800, 8'h00, 8'h99, 1, 0, "R5 base read");
    acc(0, 16'hF7FF, 8'h00, 8'h77, 0, 1, "R5 below base read");

    // R8 visible mode
    sfr_wr(8'hB1, 8'h02, 0);
    @(negedge clk); chk("R2 visible bit readback", 32'(sfr_rdata), 32'h0000_00A2);
    tick();
    acc(1, 16'hF810, 8'h6B, 8'h00, 1, 1, "R8 visible write");
    acc(0, 16'hF810, 8'h00, 8'h01, 1, 1, "R8 visible read");
    // R9 visible has no effect outside range
    acc(0, 16'h1234, 8'h00, 8'h4D, 0, 1, "R9 visible outside range");
    sfr_wr(8'hB1, 8'h03, 1);
    tick();
    acc(0, 16'hFA00, 8'h00, 8'hB2, 0, 1, "R9 visible while disabled");

    // R11 request in data cycle ignored
    sfr_wr(8'hB1, 8'h00, 1);
    tick();
    acc_valid = 1; acc_we = 0; acc_addr = 16'hFC00; p0_in = 8'h00;
    tick();
    acc_we = 1; acc_addr = 16'hFC01; acc_wdata = 8'hDD;
    @(negedge clk);
    chk("R11 busy during data cycle", 32'(acc_busy), 32'd1);
    chk("R11 no RAM strobe while busy", 32'(ram_en), 32'd0);
    chk("R11 no bus cycle while busy", 32'(bus_ale), 32'd0);
    tick();
    acc_valid = 0;
    tick(); tick();
    acc(0, 16'hFC01, 8'h00, 8'h00, 1, 0, "R11 ignored write left RAM intact");

    // Mixed traffic, checked cycle by cycle by the model
    for (int i = 0; i < 48; i++) begin
      if (i % 12 == 0) sfr_wr(8'hB1, 8'((i / 12) & 3), (i % 24) == 0);
      acc_valid = 1;
      acc_we    = (i % 3) == 0;
      acc_addr  = 16'((i * 4933 + 'hF000) & 16'hFFFF);
      acc_wdata = 8'((i * 37) & 255);
      p0_in     = 8'((i * 91 + 5) & 255);
      tick();
      if (i % 4 != 1) acc_valid = 0;
      tick();
    end
    acc_valid = 0;
    repeat (4) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule